// File: doc/BRIEF.md
# Line loss-of-signal detector

This block watches the raw received line bit, taken ahead of any B3ZS or HDB3 decoding and sampled once per line clock, and raises a loss-of-signal flag when the line has gone quiet. The flag sets as soon as the input has stayed low for a long run of samples. It clears only after the line has shown enough pulses over a complete observation window. The density needed to clear depends on the line mode: one third of the samples must be ones for DS3, and one quarter for E3.

One programmable value, the window length, sets both the zero-run length and the clearing window. The block forces it into the range 100 to 250 and uses 175 when the value is zero. Reset puts the block in the alarm state, so the line must prove itself before the flag drops. While the alarm is up, the block tests back-to-back windows that do not overlap. A window that falls short leaves the alarm set and the next window starts on the very next sample.

Top module: `los_detector`

## Requirements
- R1: While reset (`rst_n` low at a rising edge) is applied and on the first cycle after it, `los` reads 1.
- R2: The effective length L is 175 when `win_len` is 0, 100 when `win_len` is from 1 to 99, 250 when `win_len` is above 250, and `win_len` itself otherwise.
- R3: `los` becomes 1 on the rising edge that samples the L-th consecutive 0 on `line_bit`, whatever the window state.
- R4: A 1 on `line_bit` restarts the zero run, so L-1 zeros, a one, then L-1 more zeros leave `los` at 0.
- R5: While `los` is 1, samples are grouped into windows of exactly L samples. The first window starts with the first sample after reset, or with the first sample after the edge that set `los`.
- R6: With `mode_e3` = 0 (DS3), a window whose count of ones k satisfies 3·k ≥ L clears `los` on the edge that samples its last bit.
- R7: With `mode_e3` = 1 (E3), a window clears `los` when 4·k ≥ L.
- R8: A window that fails the density test leaves `los` at 1, and the next window starts with the following sample.
- R9: While `los` is 0, only a run of L zeros changes it. A string of sparse ones does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock, one sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset, sets the alarm |
| mode_e3 | input | 1 | 0 selects the DS3 threshold (1/3), 1 selects the E3 threshold (1/4) |
| line_bit | input | 1 | Raw received line data before line decoding |
| win_len | input | 8 | Requested run and window length, clamped to 100..250, 0 selects 175 |
| los | output | 1 | Loss-of-signal alarm, 1 while the line is considered lost |

## Verification
Every result appears on the same rising edge that samples the deciding bit. `los` sets on the edge that takes in the L-th zero, and it clears on the edge that takes in the last bit of a passing window. No pipeline stage comes after that edge. The bench therefore drives `line_bit` at the falling edge and reads `los` 1 ns after the rising edge. At each boundary it checks both the sample before the deciding one and the deciding sample itself. Lengths and modes are swept, and the expected L and minimum count of ones are computed as a clamp and a ceiling division in the bench.

// File: rtl/los_pkg.sv
// Package: shared types for the loss-of-signal detector.
// Assumes: nothing beyond a single-bit mode selector.
package los_pkg;
    typedef enum logic {
        MODE_DS3 = 1'b0,
        MODE_E3  = 1'b1
    } line_mode_e;
endpackage

// File: rtl/los_len_sel.sv
// Module: los_len_sel
// Turns the requested length into the effective run/window length.
// Assumes: MIN_LEN <= DEF_LEN <= MAX_LEN and all fit in LEN_W bits.
module los_len_sel #(
    parameter int LEN_W   = 8,
    parameter int MIN_LEN = 100,
    parameter int MAX_LEN = 250,
    parameter int DEF_LEN = 175
) (
    input  logic [LEN_W-1:0] req_len,
    output logic [LEN_W-1:0] eff_len
);
    localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] MAX_V = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] DEF_V = LEN_W'(DEF_LEN);

    // Pick the default for zero, otherwise clamp into range.
    always_comb begin
        if (req_len == '0)        eff_len = DEF_V;
        else if (req_len < MIN_V) eff_len = MIN_V;
        else if (req_len > MAX_V) eff_len = MAX_V;
        else                      eff_len = req_len;
    end
endmodule

// File: rtl/los_zero_run.sv
// Module: los_zero_run
// Counts consecutive zero samples, saturating at the effective length.
// Assumes: len >= 1; synchronous active-low reset.
module los_zero_run #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_bit,
    input  logic [LEN_W-1:0] len,
    output logic             run_full
);
    localparam int CW = LEN_W + 1;

    logic [LEN_W-1:0] zcnt;
    logic [CW-1:0]    zcnt_inc;

    assign zcnt_inc = {1'b0, zcnt} + CW'(1);

    // The current zero completes a run of len zeros.
    assign run_full = !line_bit && (zcnt_inc >= {1'b0, len});

    // Zero-run counter: restarts on a one, saturates at len.
    always_ff @(posedge clk) begin
        if (!rst_n)               zcnt <= '0;
        else if (line_bit)        zcnt <= '0;
        else if (zcnt_inc <= {1'b0, len}) zcnt <= zcnt_inc[LEN_W-1:0];
        else                      zcnt <= len;
    end

    // R4
    zero_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_bit |=> (zcnt == '0));

    // R3
    zero_run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_bit |=> (zcnt <= $past(len)));
endmodule

// File: rtl/los_density_win.sv
// Module: los_density_win
// Runs back-to-back windows of len samples while active and counts ones.
// Reports the last sample of a window and whether the window passed the
// density test for the selected mode.
// Assumes: len >= 1; counters idle at zero while inactive.
module los_density_win
    import los_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             line_bit,
    input  logic             mode_e3,
    input  logic [LEN_W-1:0] len,
    output logic             win_done,
    output logic             win_pass
);
    localparam int CW = LEN_W + 1;
    localparam int SW = LEN_W + 3;

    line_mode_e       mode;
    logic [LEN_W-1:0] wcnt;
    logic [LEN_W-1:0] ocnt;
    logic [CW-1:0]    wcnt_inc;
    logic [CW-1:0]    ones_tot;
    logic [SW-1:0]    scaled;

    assign mode     = line_mode_e'(mode_e3);
    assign wcnt_inc = {1'b0, wcnt} + CW'(1);
    assign ones_tot = {1'b0, ocnt} + CW'(line_bit);
    assign win_done = active && (wcnt_inc >= {1'b0, len});

    // Scale the ones count by 4 (E3) or 3 (DS3) and compare with len.
    always_comb begin
        if (mode == MODE_E3) scaled = {ones_tot, 2'b00};
        else                 scaled = {1'b0, ones_tot, 1'b0} + {2'b00, ones_tot};
        win_pass = scaled >= {3'b000, len};
    end

    // Window counters: idle when inactive, restart after each window.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || win_done) begin
            wcnt <= '0;
            ocnt <= '0;
        end else begin
            wcnt <= wcnt_inc[LEN_W-1:0];
            ocnt <= ones_tot[LEN_W-1:0];
        end
    end

    // R5
    win_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (wcnt < len));

    // R8
    win_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> (wcnt == '0 && ocnt == '0));

    // R6
    ones_le_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ocnt <= wcnt);
endmodule

// File: rtl/los_detector.sv
// Module: los_detector (top)
// Loss-of-signal alarm on the undecoded line bit: sets on a long zero run,
// clears on a passing ones-density window. Comes out of reset alarmed.
// Assumes: one sample per rising clk edge; synchronous active-low reset.
module los_detector #(
    parameter int LEN_W   = 8,
    parameter int MIN_LEN = 100,
    parameter int MAX_LEN = 250,
    parameter int DEF_LEN = 175
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_e3,
    input  logic             line_bit,
    input  logic [LEN_W-1:0] win_len,
    output logic             los
);
    logic [LEN_W-1:0] eff_len;
    logic             run_full;
    logic             win_done;
    logic             win_pass;

    los_len_sel #(
        .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .DEF_LEN(DEF_LEN)
    ) u_len (
        .req_len(win_len),
        .eff_len(eff_len)
    );

    los_zero_run #(.LEN_W(LEN_W)) u_zero (
        .clk(clk), .rst_n(rst_n), .line_bit(line_bit),
        .len(eff_len), .run_full(run_full)
    );

    los_density_win #(.LEN_W(LEN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .active(los), .line_bit(line_bit),
        .mode_e3(mode_e3), .len(eff_len),
        .win_done(win_done), .win_pass(win_pass)
    );

    // Alarm register: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     los <= 1'b1;
        else if (run_full)              los <= 1'b1;
        else if (win_done && win_pass)  los <= 1'b0;
    end

    // R2
    len_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_len >= LEN_W'(MIN_LEN)) && (eff_len <= LEN_W'(MAX_LEN)));

    // R3
    los_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_full |=> los);

    // R9
    los_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los) |-> $past(win_done && win_pass));
endmodule

// File: tb/los_detector_test.sv
// Bench: sweeps lengths and modes, computing L and the minimum ones count
// arithmetically and checking the alarm at each boundary.
module los_detector_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_e3 = 1'b0;
    logic       line_bit = 1'b0;
    logic [7:0] win_len = 8'd0;
    logic       los;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    los_detector uut (
        .clk(clk), .rst_n(rst_n), .mode_e3(mode_e3),
        .line_bit(line_bit), .win_len(win_len), .los(los)
    );

    always #10 clk = ~clk;

    task automatic chk(input logic exp, input string req, input string what);
        n_chk++;
        if (los !== exp) begin
            n_fail++;
            $display("FAIL %s %s: los actual %b expected %b (win_len=%0d mode_e3=%0b)",
                     req, what, los, exp, win_len, mode_e3);
        end
    endtask

    // One sample: drive at the falling edge, read just after the rising edge.
    task automatic step(input logic b);
        @(negedge clk);
        line_bit = b;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input logic b, input int n);
        for (int i = 0; i < n; i++) step(b);
    endtask

    function automatic int eff_of(input int w);
        if (w == 0) return 175;
        if (w < 100) return 100;
        if (w > 250) return 250;
        return w;
    endfunction

    initial begin
        int lens[6] = '{0, 50, 100, 137, 250, 255};
        for (int li = 0; li < 6; li++) begin
            for (int m = 0; m < 2; m++) begin
                int L, k;
                @(negedge clk);
                rst_n = 1'b0;
                win_len = 8'(lens[li]);
                mode_e3 = m[0];
                line_bit = 1'b0;
                @(posedge clk); @(posedge clk); #1;
                L = eff_of(lens[li]);                  // R2 expected length
                k = (m == 0) ? (L + 2) / 3 : (L + 3) / 4;
                chk(1'b1, "R1", "in reset");
                // Window 1: one one short of the threshold -> stays alarmed
                steps(1'b0, L - (k - 1));
                steps(1'b1, k - 2);
                chk(1'b1, "R5", "before end of first window");
                step(1'b1);
                chk(1'b1, "R8", "short window keeps alarm");
                // Window 2: exactly the threshold -> clears on its last bit
                steps(1'b0, L - k);
                steps(1'b1, k - 1);
                chk(1'b1, "R8", "new window one sample short");
                step(1'b1);
                chk(1'b0, (m == 0) ? "R6" : "R7", "threshold window clears");
                // Zero runs broken by a one do not set the alarm
                steps(1'b0, L - 1);
                chk(1'b0, "R3", "L-1 zeros");
                step(1'b1);
                chk(1'b0, "R9", "sparse one while clear");
                steps(1'b0, L - 1);
                chk(1'b0, "R4", "run restarted by one");
                step(1'b0);
                chk(1'b1, "R3", "L-th zero sets alarm");
                // First window after set starts with the next sample
                steps(1'b0, L - k);
                steps(1'b1, k - 1);
                chk(1'b1, "R5", "window after set one short");
                step(1'b1);
                chk(1'b0, (m == 0) ? "R6" : "R7", "window after set clears");
            end
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule